// File: doc/BRIEF.md
# DRAM Refresh Scheduler (CAS-first strobe ordering)

This block keeps every row of an asynchronous DRAM refreshed without help from the host logic. A free-running divider produces one refresh credit per interval (one row every 32 ms / 2048, about 15.6 µs). Credits collect in a bounded backlog. While the backlog is non-zero the scheduler asks the access controller for the strobes. Once the controller answers that its row is closed and precharge has finished, the scheduler runs a complete refresh cycle on the strobe pins.

In the normal mode, column strobe falls first and row strobe follows, so the memory advances its own internal row counter and no address is driven. A mode input selects the alternative: row-strobe-only refresh, in which the block drives a row number from its own wrapping counter and keeps column strobe high. The backlog lets refreshes be put off for a while under heavy traffic. When the backlog reaches a threshold, an urgency flag tells the controller that refresh now has absolute priority.

Top module: `rfsh_sched`

## Requirements
- R1: In reset and on the first cycle after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `dram_addr_oe`, `rf_req`, `rf_busy` and `rf_urgent` are 0, and `backlog` is 0.
- R2: `backlog` grows by one on every TICK_DIV-th clock edge after reset is released. The first step comes on edge TICK_DIV.
- R3: `backlog` never exceeds MAX_PENDING, where further credits are dropped. It falls by one on the edge that ends each refresh precharge. A credit and a completion on the same edge leave it unchanged.
- R4: `rf_req` is 1 while the scheduler is waiting for a grant with a non-zero backlog. No strobe moves until `ctrl_ack` is sampled 1 on an edge where `rf_req` is 1.
- R5: `rf_urgent` is 1 exactly while `backlog` >= URGENT_AT.
- R6: In column-first mode (`mode_ras_only` = 0), the edge that takes the grant drives `dram_cas_n` to 0 and `rf_busy` to 1. `dram_ras_n` falls CAS_LEAD cycles later while `dram_cas_n` is still 0.
- R7: `dram_ras_n` stays 0 for exactly RAS_LOW cycles. Then `dram_ras_n` and `dram_cas_n` both rise, and `rf_busy` stays 1 for exactly PRECH more cycles with both strobes high.
- R8: `dram_we_n` is 1 on every cycle.
- R9: In column-first mode `dram_addr_oe` stays 0 for the whole refresh.
- R10: In row-only mode (`mode_ras_only` = 1), `dram_cas_n` stays 1 and `dram_addr_oe` is 1 from the grant edge until row strobe rises. `dram_addr` carries the internal row counter, which starts at 0 after reset, steps once per row-only refresh, wraps after 2**ROW_BITS rows and does not move on column-first refreshes.
- R11: The mode is sampled on the grant edge. Changing `mode_ras_only` during a refresh does not alter that refresh.
- R12: When a refresh ends with the backlog still non-zero, `rf_req` is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ras_only | input | 1 | 1 selects row-only refresh with a driven row address |
| ctrl_ack | input | 1 | Controller grant: its row is closed and precharged |
| rf_req | output | 1 | Refresh wanted, waiting for grant |
| rf_urgent | output | 1 | Backlog at or above the urgency threshold |
| rf_busy | output | 1 | Scheduler owns the strobes |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low, held high |
| dram_addr | output | ROW_BITS | Row number for row-only refresh |
| dram_addr_oe | output | 1 | Address drive enable |
| backlog | output | $clog2(MAX_PENDING+1) | Refresh credits outstanding |

## Verification
On every cycle the embedded assertions check several local rules. Credits and completions each move the backlog by exactly one step. No strobe moves while the grant is absent. Column strobe is low whenever row strobe falls in column-first mode, and it stays high with the address driven in row-only mode. Row strobe pulses have the programmed width. Other properties only the bench's scenarios can show. These include the exact cadence of credits, saturation after a long grant-free stretch, and the urgency threshold crossing. They also include the lead and precharge spacing, the row counter's sequence and wrap, its stillness across column-first refreshes, and immunity to a mode change in mid-cycle.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_GRANT,
    ST_LEAD,
    ST_ROW_LOW,
    ST_PRECH
  } rfsh_state_e;
endpackage

// File: rtl/rfsh_tick_timer.sv
module rfsh_tick_timer #(
  parameter int TICK_DIV = 780
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int MAX_PENDING = 8,
  parameter int URGENT_AT   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic credit,
  input  logic done,
  output logic [$clog2(MAX_PENDING+1)-1:0] pending,
  output logic urgent,
  output logic nonzero
);
  localparam int PW = $clog2(MAX_PENDING + 1);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PENDING);
  localparam logic [PW-1:0] PURG = PW'(URGENT_AT);

  logic [PW-1:0] pend_q, pend_n;
  logic          urg_q;

  always_comb begin
    pend_n = pend_q;
    if (credit && !done) begin
      if (pend_q != PMAX) pend_n = pend_q + 1'b1;
    end else if (done && !credit) begin
      if (pend_q != '0) pend_n = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      urg_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      urg_q  <= (pend_n >= PURG);
    end
  end

  assign pending = pend_q;
  assign urgent  = urg_q;
  assign nonzero = (pend_q != '0);

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
    pend_q <= PMAX); // R3
  AST_CREDIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (credit && !done && pend_q != PMAX) |=> (pend_q == $past(pend_q) + 1'b1)); // R2
  AST_DONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (done && !credit) |=> (pend_q == $past(pend_q) - 1'b1)); // R3
  AST_URGENT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    urg_q |-> (pend_q != '0)); // R5
endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
  import rfsh_pkg::*;
#(
  parameter int CAS_LEAD = 1,
  parameter int RAS_LOW  = 3,
  parameter int PRECH    = 2,
  parameter int ROW_BITS = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                have_work,
  input  logic                ack,
  input  logic                mode_ro,
  output logic                done,
  output logic                req,
  output logic                busy,
  output logic                ras_n,
  output logic                cas_n,
  output logic                addr_oe,
  output logic [ROW_BITS-1:0] addr
);
  localparam int MAXD = (CAS_LEAD > RAS_LOW) ?
                        ((CAS_LEAD > PRECH) ? CAS_LEAD : PRECH) :
                        ((RAS_LOW > PRECH) ? RAS_LOW : PRECH);
  localparam int DW = $clog2(MAXD + 1);
  localparam int RW = $clog2(RAS_LOW + 2);

  rfsh_state_e       st_q, st_n;
  logic [DW-1:0]     cnt_q, cnt_n;
  logic              mode_q, mode_n;
  logic [ROW_BITS-1:0] row_q;
  logic              req_q, busy_q, ras_n_q, cas_n_q, oe_q;
  logic [ROW_BITS-1:0] addr_q;
  logic              strobing_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    mode_n = mode_q;
    done   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (have_work) st_n = ST_WAIT_GRANT;
      ST_WAIT_GRANT: if (ack) begin
        st_n   = ST_LEAD;
        cnt_n  = DW'(CAS_LEAD - 1);
        mode_n = mode_ro;
      end
      ST_LEAD: begin
        if (cnt_q == '0) begin
          st_n  = ST_ROW_LOW;
          cnt_n = DW'(RAS_LOW - 1);
        end else cnt_n = cnt_q - 1'b1;
      end
      ST_ROW_LOW: begin
        if (cnt_q == '0) begin
          st_n  = ST_PRECH;
          cnt_n = DW'(PRECH - 1);
        end else cnt_n = cnt_q - 1'b1;
      end
      ST_PRECH: begin
        if (cnt_q == '0) begin
          st_n = ST_IDLE;
          done = 1'b1;
        end else cnt_n = cnt_q - 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign strobing_n = (st_n == ST_LEAD) || (st_n == ST_ROW_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      row_q   <= '0;
      req_q   <= 1'b0;
      busy_q  <= 1'b0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      oe_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      mode_q  <= mode_n;
      if (done && mode_q) row_q <= row_q + 1'b1;
      req_q   <= (st_n == ST_WAIT_GRANT);
      busy_q  <= strobing_n || (st_n == ST_PRECH);
      ras_n_q <= (st_n != ST_ROW_LOW);
      cas_n_q <= !(strobing_n && !mode_n);
      oe_q    <= strobing_n && mode_n;
      addr_q  <= (strobing_n && mode_n) ? row_q : '0;
    end
  end

  assign req     = req_q;
  assign busy    = busy_q;
  assign ras_n   = ras_n_q;
  assign cas_n   = cas_n_q;
  assign addr_oe = oe_q;
  assign addr    = addr_q;

  logic [RW-1:0] low_run_q;
  always_ff @(posedge clk) begin
    if (rst)                 low_run_q <= '0;
    else if (ras_n_q)        low_run_q <= '0;
    else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
  end

  AST_NO_STROBE_WO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT_GRANT && !ack) |=> (ras_n_q && cas_n_q)); // R4
  AST_REQ_HAS_WORK: assert property (@(posedge clk) disable iff (rst)
    req_q |-> have_work); // R4
  AST_CAS_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n_q) && !mode_q) |-> !cas_n_q); // R6
  AST_RO_CAS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!ras_n_q && mode_q) |-> (cas_n_q && oe_q)); // R10
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n_q) |-> (low_run_q == RW'(RAS_LOW))); // R7
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int TICK_DIV    = 780,
  parameter int MAX_PENDING = 8,
  parameter int URGENT_AT   = 6,
  parameter int CAS_LEAD    = 1,
  parameter int RAS_LOW     = 3,
  parameter int PRECH       = 2,
  parameter int ROW_BITS    = 11
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               mode_ras_only,
  input  logic                               ctrl_ack,
  output logic                               rf_req,
  output logic                               rf_urgent,
  output logic                               rf_busy,
  output logic                               dram_ras_n,
  output logic                               dram_cas_n,
  output logic                               dram_we_n,
  output logic [ROW_BITS-1:0]                dram_addr,
  output logic                               dram_addr_oe,
  output logic [$clog2(MAX_PENDING+1)-1:0]   backlog
);
  logic credit, done, work;

  rfsh_tick_timer #(.TICK_DIV(TICK_DIV)) u_timer (
    .clk (clk),
    .rst (rst),
    .tick(credit)
  );

  rfsh_backlog #(.MAX_PENDING(MAX_PENDING), .URGENT_AT(URGENT_AT)) u_backlog (
    .clk    (clk),
    .rst    (rst),
    .credit (credit),
    .done   (done),
    .pending(backlog),
    .urgent (rf_urgent),
    .nonzero(work)
  );

  rfsh_strobe_seq #(
    .CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .PRECH(PRECH), .ROW_BITS(ROW_BITS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .have_work(work),
    .ack      (ctrl_ack),
    .mode_ro  (mode_ras_only),
    .done     (done),
    .req      (rf_req),
    .busy     (rf_busy),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .addr_oe  (dram_addr_oe),
    .addr     (dram_addr)
  );

  assign dram_we_n = 1'b1;

  AST_BUSY_XOR_REQ: assert property (@(posedge clk) disable iff (rst)
    !(rf_busy && rf_req)); // R4
endmodule

// File: tb/rfsh_sched_tb.sv
module rfsh_sched_tb;
  localparam int TD = 24, MAXP = 6, URG = 4, CL = 1, RL = 3, PC = 2, RB = 4;
  localparam int PW = $clog2(MAXP + 1);

  logic clk = 1'b0, rst = 1'b1, mode = 1'b0, ack = 1'b0;
  logic req, urgent, busy, ras_n, cas_n, we_n, oe;
  logic [RB-1:0] addr;
  logic [PW-1:0] backlog;

  always #10 clk = ~clk;

  rfsh_sched #(.TICK_DIV(TD), .MAX_PENDING(MAXP), .URGENT_AT(URG), .CAS_LEAD(CL),
               .RAS_LOW(RL), .PRECH(PC), .ROW_BITS(RB)) u_dut (
    .clk(clk), .rst(rst), .mode_ras_only(mode), .ctrl_ack(ack),
    .rf_req(req), .rf_urgent(urgent), .rf_busy(busy), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_addr(addr), .dram_addr_oe(oe),
    .backlog(backlog));

  typedef struct packed { logic ro; logic [RB-1:0] row; } item_t;
  item_t exp_q[$];
  item_t cur;

  int vectors = 0, fails = 0, n = 0, pm = 0, rowm = 0;
  int lead_run = 0, ras_run = 0, prech_run = 0;
  bit prev_busy = 0, prev_ras = 1, after_ras = 0, req_next_due = 0, exp_req = 0, finished = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, expv, $time);
    end
  endtask

  always @(posedge clk) if (rst) n <= 0; else n <= n + 1;

  // driver side of the scoreboard: a grant is about to be taken
  always @(negedge clk) if (!rst && req && ack) begin
    exp_q.push_back(item_t'{ro: mode, row: RB'(rowm)});
    if (mode) rowm = (rowm + 1) % (1 << RB);
  end

  // monitor
  always @(negedge clk) begin
    if (rst) begin
      chk(ras_n && cas_n && we_n, "R1 strobes", {ras_n, cas_n, we_n}, 7);
      chk(!oe && !req && !busy && !urgent && backlog == 0, "R1 flags", backlog, 0);
      pm = 0; prev_busy = 0; prev_ras = 1;
    end else begin
      bit tk, dn;
      tk = (n > 0) && (n % TD == 0);
      dn = prev_busy && !busy;
      pm = pm + int'(tk) - int'(dn);
      if (pm > MAXP) pm = MAXP;
      chk(backlog == PW'(pm), "R2,R3 backlog", backlog, pm);
      chk(urgent == (pm >= URG), "R5 urgent", urgent, pm >= URG);
      chk(we_n, "R8 we_n", we_n, 1);
      if (req_next_due) begin
        chk(req == exp_req, "R12 rerequest", req, exp_req);
        req_next_due = 0;
      end
      if (busy && ras_n && !after_ras) lead_run++;
      if (prev_ras && !ras_n) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unrequested strobe", 0, 1);
          cur = '0;
        end else begin
          cur = exp_q.pop_front();
          chk(busy, "R6 busy", busy, 1);
          chk(lead_run == CL, "R6 lead", lead_run, CL);
          if (!cur.ro) begin
            chk(!cas_n, "R6 cas first", cas_n, 0);
            chk(!oe, "R9 addr_oe", oe, 0);
          end else begin
            chk(cas_n && oe, "R10 cas/oe", {cas_n, oe}, 3);
            chk(addr == cur.row, "R10 row", addr, cur.row);
          end
        end
        after_ras = 1;
        ras_run = 0;
      end
      if (!ras_n) begin
        ras_run++;
        chk(cas_n == cur.ro, "R11 kind held", cas_n, cur.ro);
      end
      if (!prev_ras && ras_n) begin
        chk(ras_run == RL, "R7 ras width", ras_run, RL);
        chk(cas_n && !oe, "R7 release", {cas_n, oe}, 2);
      end
      if (busy && ras_n && after_ras) prech_run++;
      if (dn) begin
        chk(prech_run == PC, "R7 precharge", prech_run, PC);
        req_next_due = 1;
        exp_req = (pm != 0);
        lead_run = 0; prech_run = 0; after_ras = 0;
      end
      prev_busy = busy;
      prev_ras = ras_n;
    end
  end

  task automatic set_ack(input bit v);
    @(posedge clk); #1 ack = v;
  endtask

  task automatic set_mode(input bit v);
    @(posedge clk); #1 mode = v;
  endtask

  task automatic finish_run;
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // grant withheld: backlog fills and saturates, no strobes (R4, R3, R5)
    repeat (TD * (MAXP + 2)) @(posedge clk);
    @(negedge clk);
    chk(backlog == MAXP, "R3 saturated", backlog, MAXP);
    chk(req, "R4 request held", req, 1);
    chk(ras_n && cas_n, "R4 no strobe", {ras_n, cas_n}, 3);
    chk(urgent, "R5 urgent at max", urgent, 1);
    // grant: drain in column-first mode (R6, R7, R9, R12)
    set_ack(1);
    repeat (200) @(posedge clk);
    // row-only mode past the row wrap (R10)
    set_mode(1);
    repeat (TD * 40) @(posedge clk);
    // mode flips in mid-cycle (R11)
    for (int i = 0; i < 6; i++) begin
      @(posedge busy);
      #1 mode = ~mode;
    end
    // column-first stretch, then row-only again: counter must not have moved (R10)
    set_mode(0);
    repeat (TD * 5) @(posedge clk);
    set_mode(1);
    repeat (TD * 5) @(posedge clk);
    // short grant-free stretch then release
    set_ack(0);
    repeat (TD * 3) @(posedge clk);
    set_ack(1);
    repeat (TD * 4) @(posedge clk);
    wait (!busy);
    @(negedge clk);
    chk(exp_q.size() == 0, "R4 every grant strobed", exp_q.size(), 0);
    finish_run();
  end
endmodule